// File: doc/BRIEF.md
# I2C SCL Clock Prescaler and Divider

This block derives the serial-clock timing of an I2C master from a reference baud-rate clock. A two-bit select chooses a coarse prescale factor of 32, 16, 8 or 4. An 8-bit divider value, plus a fixed offset of three and an extra two when the digital input filter is on, sets how many prescaled steps make up one half of the SCL period. It produces a one-cycle tick at each half-period boundary and a free-running SCL reference level that toggles on every tick. An I2C bit engine uses both to place its SDA and SCL edges.

Settings may be changed at any time. New values are captured only when a full SCL period ends, which is the tick that drives the level from low to high. Every period therefore runs with a single, consistent set of settings and no shortened pulse appears. While the enable is low, both counters sit at zero, the level rests high and the inputs are captured continuously. The first half-period after enable begins cleanly from zero.

Top module: `i2c_scl_div`

## Requirements
- R1: While reset is asserted, `scl_o` is 1 and `tick_o` is 0.
- R2: The prescale factor is 32, 16, 8 or 4 for `pre_sel_i` values 0, 1, 2 and 3.
- R3: The half period, which is the number of cycles between consecutive ticks, equals prescale × (`div_i` + 3 + 2×`filt_i`). A set filter bit adds two prescaled steps to each half.
- R4: `tick_o` is high for exactly one cycle. `scl_o` inverts in the cycle after a tick and holds its value in every other enabled cycle.
- R5: Settings are captured only on a tick that takes `scl_o` from 0 to 1. A change made earlier in a period does not alter that period. A change that is present on the same cycle as the capturing tick governs the next period.
- R6: While `en_i` is 0, `scl_o` is 1, `tick_o` is 0 and settings are captured every cycle. If `en_i` drops on a tick cycle, `scl_o` returns to 1. After `en_i` rises, the first tick appears when prescale × (`div_i`+3+2×`filt_i`) − 1 enabled clock edges have passed.
- R7: All 8 bits of `div_i` are used. The values 0 and 255 give half periods of prescale×3 and prescale×258 when the filter is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference baud-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds counters at zero |
| pre_sel_i | input | 2 | Prescale select (0:32, 1:16, 2:8, 3:4) |
| filt_i | input | 1 | Input filter on; lengthens each half by two prescaled steps |
| div_i | input | 8 | Programmable divider value |
| tick_o | output | 1 | One-cycle half-period boundary pulse |
| scl_o | output | 1 | SCL reference level, toggles on each tick |

## Verification
Two events can fall on the same clock edge: a settings change and the period-ending tick that captures settings. The bench provokes this by changing the divider on the exact cycle where a rising-edge tick is visible, and expects the new value to govern the very next half. It contrasts this with a change made one half earlier, which must not take effect until a full period has passed. A second collision drops the enable on a tick cycle; here the forced-high rest level must override the toggle. The behavioural model is compared with both outputs on every cycle, and explicit interval measurements judge each half-period against the formula.

// File: rtl/i2c_scl_div_pkg.sv
package i2c_scl_div_pkg;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned PRE_LOG2 = 5;
  localparam int unsigned HALF_W   = DIV_W + 1;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             filt;
    logic [DIV_W-1:0] div;
  } scl_cfg_t;
endpackage

// File: rtl/i2c_scl_cfg_hold.sv
module i2c_scl_cfg_hold
  import i2c_scl_div_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  scl_cfg_t cfg_i,
  output scl_cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (load_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/i2c_scl_pre_cnt.sv
module i2c_scl_pre_cnt
  import i2c_scl_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             strobe_o
);
  localparam int unsigned PreW = PRE_LOG2;

  logic [PreW-1:0] cnt_q;
  logic [PreW:0]   span;
  logic [PreW-1:0] last;

  // factor = 2^PRE_LOG2 >> sel
  assign span     = (PreW+1)'(1) << (PRE_LOG2 - int'(sel_i));
  assign last     = PreW'(span - (PreW+1)'(1));
  assign strobe_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + PreW'(1);
  end
endmodule

// File: rtl/i2c_scl_half_cnt.sv
module i2c_scl_half_cnt
  import i2c_scl_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             filt_i,
  output logic             wrap_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] last;

  // steps per half = div + 3 + 2*filt, counted from zero
  assign last   = HALF_W'(div_i) + HALF_W'(2) + HALF_W'({filt_i, 1'b0});
  assign wrap_o = step_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/i2c_scl_div.sv
module i2c_scl_div
  import i2c_scl_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] pre_sel_i,
  input  logic             filt_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             scl_o
);
  scl_cfg_t cfg_in, cfg_act;
  logic     load, strobe, wrap, scl_q;

  assign cfg_in = '{sel: pre_sel_i, filt: filt_i, div: div_i};
  // capture while idle, or at the end of a full period (low -> high)
  assign load   = !en_i || (wrap && !scl_q);

  i2c_scl_cfg_hold u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_act)
  );

  i2c_scl_pre_cnt u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i),
    .sel_i    (cfg_act.sel),
    .strobe_o (strobe)
  );

  i2c_scl_half_cnt u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .step_i (strobe),
    .div_i  (cfg_act.div),
    .filt_i (cfg_act.filt),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    scl_q <= 1'b1;
    else if (!en_i) scl_q <= 1'b1;
    else if (wrap)  scl_q <= ~scl_q;
  end

  assign tick_o = wrap;
  assign scl_o  = scl_q;
endmodule

// File: rtl/i2c_scl_div_chk.sv
module i2c_scl_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_o,
  input logic scl_o
);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && en_i) |=> (scl_o != $past(scl_o)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && en_i) |=> $stable(scl_o));

  a_r6_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !tick_o));
endmodule

bind i2c_scl_div i2c_scl_div_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .tick_o (tick_o),
  .scl_o  (scl_o)
);

// File: tb/i2c_scl_div_tb.sv
`timescale 1ns/1ps
module i2c_scl_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       en_i = 1'b0;
  logic [1:0] pre_sel_i = 2'd0;
  logic       filt_i = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       tick_o, scl_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  i2c_scl_div u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pre_sel_i(pre_sel_i),
    .filt_i(filt_i), .div_i(div_i), .tick_o(tick_o), .scl_o(scl_o)
  );

  // behavioural reference
  int m_pre, m_half, m_sel, m_filt, m_div;
  bit m_scl;
  function automatic int pre_f(int s); return 32 >> s; endfunction
  function automatic int half_f(int d, int f); return d + 3 + 2*f; endfunction
  function automatic bit m_tick();
    return (m_pre == pre_f(m_sel)-1) && (m_half == half_f(m_div, m_filt)-1);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_half = 0; m_scl = 1; m_sel = 0; m_filt = 0; m_div = 0;
    end else if (!en_i) begin
      m_pre = 0; m_half = 0; m_scl = 1;
      m_sel = pre_sel_i; m_filt = filt_i; m_div = div_i;
    end else begin
      bit t;
      t = m_tick();
      if (m_pre == pre_f(m_sel)-1) begin
        m_pre = 0;
        m_half = (m_half == half_f(m_div, m_filt)-1) ? 0 : m_half + 1;
      end else m_pre++;
      if (t) begin
        if (!m_scl) begin m_sel = pre_sel_i; m_filt = filt_i; m_div = div_i; end
        m_scl = !m_scl;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle model comparison (R4 tick, R4 level)
  always @(negedge clk_i) if (rst_ni && !done) begin
    check(tick_o == m_tick(), "R4 tick vs model", tick_o, m_tick());
    check(scl_o == m_scl, "R4 scl vs model", scl_o, m_scl);
  end

  task automatic wait_tick();
    do @(negedge clk_i); while (!tick_o);
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tick_o);
  endtask

  task automatic start(int s, int f, int d);
    @(negedge clk_i);
    en_i = 0; pre_sel_i = 2'(s); filt_i = f[0]; div_i = 8'(d);
    @(negedge clk_i);
    en_i = 1;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, n2;
    #1 rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check(scl_o == 1, "R1 scl in reset", scl_o, 1);
    check(tick_o == 0, "R1 tick in reset", tick_o, 0);
    rst_ni = 1;
    repeat (5) @(negedge clk_i);
    check(scl_o == 1 && tick_o == 0, "R6 idle rest", scl_o, 1);

    // R6 first tick after enable, R7 div=0
    @(negedge clk_i); pre_sel_i = 3; filt_i = 0; div_i = 0;
    @(negedge clk_i); en_i = 1;
    interval(n);
    check(n == 11, "R6 first tick after enable", n, 11);
    interval(n);
    check(n == 12, "R7 div zero half", n, 12);

    // R2 and R3 across all prescale selects with filter on
    for (int s = 0; s < 4; s++) begin
      start(s, 1, 5);
      wait_tick();
      interval(n);
      check(n == (32 >> s) * 10, $sformatf("R2 sel=%0d", s), n, (32 >> s) * 10);
    end

    // R3 filter effect
    start(3, 0, 1); wait_tick(); interval(n);
    check(n == 16, "R3 filter off", n, 16);
    start(3, 1, 1); wait_tick(); interval(n);
    check(n == 24, "R3 filter on", n, 24);

    // R5 change mid-period: not applied until the next rising boundary
    start(3, 0, 2);
    do wait_tick(); while (!scl_o);
    div_i = 10;
    interval(n); interval(n2);
    check(n == 20, "R5 mid-period change deferred", n, 20);
    check(n2 == 52, "R5 change applied next period", n2, 52);

    // R5 change on the same cycle as the capturing tick
    do wait_tick(); while (scl_o);
    div_i = 2;
    interval(n); interval(n2);
    check(n == 20, "R5 same-cycle change first half", n, 20);
    check(n2 == 20, "R5 same-cycle change second half", n2, 20);

    // R6 enable dropped on a tick cycle
    do wait_tick(); while (scl_o);
    en_i = 0;
    @(negedge clk_i);
    check(scl_o == 1, "R6 drop on tick forces high", scl_o, 1);
    check(tick_o == 0, "R6 no tick while idle", tick_o, 0);
    repeat (4) @(negedge clk_i);
    check(scl_o == 1, "R6 idle stays high", scl_o, 1);

    // R7 maximum divider
    start(3, 0, 255); wait_tick(); interval(n);
    check(n == 1032, "R7 div 255", n, 1032);
    start(0, 1, 255); wait_tick(); interval(n);
    check(n == 8320, "R7 longest half", n, 8320);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule